// File: doc/BRIEF.md
# Banked Data-Memory Address Generator

This block turns the operand of a register-file access into one physical byte address in a data memory of four banks. A direct access joins the two bank-select bits to the 7-bit operand field. An operand field of zero names a virtual alias register. The address then comes from an 8-bit pointer extended by one bank-extension bit. After that choice the logical address is folded: the status register, the shared window at the top of each bank, and the general-purpose area that bank 3 borrows from bank 1 each resolve to a single physical byte.

The register file sits next to the block and uses its outputs directly. Each access presents a read or write strobe together with the operand and the bank state. One clock later the block returns the physical address, a valid strobe and three flags. The flags tell the file to return zero instead of reading, or to drop the write. This happens when the pointer targets the alias itself or when the resolved byte is not implemented.

Top module: `bank_addr_gen`

## Requirements
- R1: With a nonzero operand field, the logical address is {bank_sel[1:0], ofs_field[6:0]}.
- R2: With ofs_field equal to 00h, the logical address is {ind_ext, ptr[7:0]}: ind_ext = 0 reaches 000h-0FFh and ind_ext = 1 reaches 100h-1FFh.
- R3: An indirect access whose logical address has bits [6:0] all zero targets the alias. It drives phys_addr to 000h, raises rd_zero on a read and raises wr_kill on a write.
- R4: A logical address with bits [6:0] in 70h-7Fh resolves to bank 0 at the same offset (phys_addr[8:7] = 0), whatever the bank.
- R5: A logical address with bits [6:0] equal to 03h resolves to 003h in every bank.
- R6: A logical address in bank 3 with bits [6:0] in 20h-6Fh resolves to bank 1 at the same offset (phys_addr[8:7] = 01b).
- R7: Physical addresses 007h-009h are unimplemented. An access that resolves there raises unimpl, plus rd_zero on a read and wr_kill on a write.
- R8: All outputs are registered. The result of the inputs sampled at one rising edge appears right after that edge, and out_valid equals acc_rd OR acc_wr of that edge.
- R9: While rst_n is low at a rising edge, every output is cleared to zero.
- R10: With neither acc_rd nor acc_wr, rd_zero, wr_kill, unimpl and out_valid stay 0, while phys_addr still follows the folding rules.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| acc_rd | input | 1 | Read access this cycle |
| acc_wr | input | 1 | Write access this cycle |
| ofs_field | input | 7 | Operand offset from the instruction |
| bank_sel | input | 2 | Direct bank-select bits |
| ind_ext | input | 1 | Bank-extension bit for pointer accesses |
| ptr | input | 8 | Pointer register value |
| out_valid | output | 1 | Registered access strobe |
| phys_addr | output | 9 | Resolved physical byte address |
| rd_zero | output | 1 | Return zero instead of reading |
| wr_kill | output | 1 | Suppress the write |
| unimpl | output | 1 | Access resolved to an unimplemented byte |

## Verification
Every result has a latency of one register. The address, the flags and the valid strobe for inputs driven before a rising edge are all due just after that edge. The bench drives on the falling edge and samples 1 ns after the next rising edge, before it drives anything new. The reset check samples while reset is still held. Each sample is compared with a bench model built from the folding order: alias, then status, then shared window, then bank 3 shadow, then the unimplemented range.

// File: rtl/bank_addr_pkg.sv
// Package: shared widths and address types for the banked address generator.
// Assumes four banks of 128 bytes each, so the address is 9 bits wide.
package bank_addr_pkg;
    localparam int OFS_W  = 7;
    localparam int BANK_W = 2;
    localparam int ADDR_W = BANK_W + OFS_W;
    localparam int PTR_W  = ADDR_W - 1;

    typedef logic [OFS_W-1:0]  ofs_t;
    typedef logic [BANK_W-1:0] bank_t;

    typedef struct packed {
        bank_t bank;
        ofs_t  ofs;
    } daddr_t;
endpackage

// File: rtl/bank_addr_select.sv
// Module: picks the direct or pointer-based logical address.
// Assumes an operand field of zero names the alias register.
module bank_addr_select
    import bank_addr_pkg::*;
(
    input  ofs_t              ofs_field,
    input  bank_t             bank_sel,
    input  logic              ind_ext,
    input  logic [PTR_W-1:0]  ptr,
    output daddr_t            logic_addr,
    output logic              is_ind
);
    // Choose the address source from the operand field.
    always_comb begin
        is_ind = (ofs_field == '0);
        if (is_ind) begin
            logic_addr = daddr_t'({ind_ext, ptr});
        end else begin
            logic_addr = '{bank: bank_sel, ofs: ofs_field};
        end
    end
endmodule

// File: rtl/bank_addr_fold.sv
// Module: folds mirrored locations of a logical address onto one physical byte.
// Assumes the alias check runs first and passes self_ref in.
// Precedence: alias, status, shared window, bank 3 shadow.
module bank_addr_fold
    import bank_addr_pkg::*;
#(
    parameter logic [OFS_W-1:0]  STATUS_OFS = 7'h03,
    parameter logic [OFS_W-1:0]  COMMON_LO  = 7'h70,
    parameter logic [OFS_W-1:0]  SHADOW_LO  = 7'h20,
    parameter logic [BANK_W-1:0] SHADOW_SRC = 2'd3,
    parameter logic [BANK_W-1:0] SHADOW_DST = 2'd1
) (
    input  daddr_t logic_addr,
    input  logic   self_ref,
    output daddr_t phys
);
    // Apply the folding rules in priority order.
    always_comb begin
        phys = logic_addr;
        if (self_ref) begin
            phys = '0;
        end else if (logic_addr.ofs == STATUS_OFS) begin
            phys = '{bank: '0, ofs: STATUS_OFS};
        end else if (logic_addr.ofs >= COMMON_LO) begin
            phys = '{bank: '0, ofs: logic_addr.ofs};
        end else if (logic_addr.bank == SHADOW_SRC && logic_addr.ofs >= SHADOW_LO) begin
            phys = '{bank: SHADOW_DST, ofs: logic_addr.ofs};
        end
    end
endmodule

// File: rtl/bank_addr_guard.sv
// Module: detects alias self-reference and unimplemented physical bytes.
// Assumes the unimplemented range lies in bank 0; UNIMPL_EN = 0 removes it.
module bank_addr_guard
    import bank_addr_pkg::*;
#(
    parameter bit               UNIMPL_EN = 1'b1,
    parameter logic [OFS_W-1:0] UNIMPL_LO = 7'h07,
    parameter logic [OFS_W-1:0] UNIMPL_HI = 7'h09
) (
    input  daddr_t logic_addr,
    input  logic   is_ind,
    input  daddr_t phys,
    output logic   self_ref,
    output logic   hole
);
    // Flag a pointer that targets an alias location.
    always_comb self_ref = is_ind && (logic_addr.ofs == '0);

    generate
        if (UNIMPL_EN) begin : g_hole
            // Flag physical bytes inside the unimplemented range.
            always_comb hole = (phys.bank == '0) &&
                               (phys.ofs >= UNIMPL_LO) && (phys.ofs <= UNIMPL_HI);
        end else begin : g_nohole
            // No unimplemented range in this variant.
            always_comb hole = 1'b0;
        end
    endgenerate
endmodule

// File: rtl/bank_addr_gen.sv
// Module: top of the banked address generator. Selects, folds and guards the
// address, then registers the result for the register file.
// Assumes acc_rd and acc_wr are sampled together with the operand and bank state.
module bank_addr_gen
    import bank_addr_pkg::*;
#(
    parameter logic [OFS_W-1:0]  STATUS_OFS = 7'h03,
    parameter logic [OFS_W-1:0]  COMMON_LO  = 7'h70,
    parameter logic [OFS_W-1:0]  SHADOW_LO  = 7'h20,
    parameter logic [BANK_W-1:0] SHADOW_SRC = 2'd3,
    parameter logic [BANK_W-1:0] SHADOW_DST = 2'd1,
    parameter bit                UNIMPL_EN  = 1'b1,
    parameter logic [OFS_W-1:0]  UNIMPL_LO  = 7'h07,
    parameter logic [OFS_W-1:0]  UNIMPL_HI  = 7'h09
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_rd,
    input  logic              acc_wr,
    input  logic [6:0]        ofs_field,
    input  logic [1:0]        bank_sel,
    input  logic              ind_ext,
    input  logic [7:0]        ptr,
    output logic              out_valid,
    output logic [8:0]        phys_addr,
    output logic              rd_zero,
    output logic              wr_kill,
    output logic              unimpl
);
    daddr_t logic_addr;
    daddr_t phys;
    logic   is_ind;
    logic   self_ref;
    logic   hole;
    logic   blocked;

    bank_addr_select u_sel (
        .ofs_field  (ofs_field),
        .bank_sel   (bank_sel),
        .ind_ext    (ind_ext),
        .ptr        (ptr),
        .logic_addr (logic_addr),
        .is_ind     (is_ind)
    );

    bank_addr_guard #(
        .UNIMPL_EN (UNIMPL_EN),
        .UNIMPL_LO (UNIMPL_LO),
        .UNIMPL_HI (UNIMPL_HI)
    ) u_guard (
        .logic_addr (logic_addr),
        .is_ind     (is_ind),
        .phys       (phys),
        .self_ref   (self_ref),
        .hole       (hole)
    );

    bank_addr_fold #(
        .STATUS_OFS (STATUS_OFS),
        .COMMON_LO  (COMMON_LO),
        .SHADOW_LO  (SHADOW_LO),
        .SHADOW_SRC (SHADOW_SRC),
        .SHADOW_DST (SHADOW_DST)
    ) u_fold (
        .logic_addr (logic_addr),
        .self_ref   (self_ref),
        .phys       (phys)
    );

    // Any reason the file must not touch storage.
    always_comb blocked = self_ref | hole;

    // Register the resolved address and the access flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            phys_addr <= '0;
            rd_zero   <= 1'b0;
            wr_kill   <= 1'b0;
            unimpl    <= 1'b0;
        end else begin
            out_valid <= acc_rd | acc_wr;
            phys_addr <= phys;
            rd_zero   <= acc_rd & blocked;
            wr_kill   <= acc_wr & blocked;
            unimpl    <= (acc_rd | acc_wr) & hole;
        end
    end

    // R4: no bank other than 0 ever carries a shared-window offset.
    a_r4_common_folded: assert property (@(posedge clk) disable iff (!rst_n)
        (phys_addr[8:7] != 2'd0) |-> (phys_addr[6:0] < COMMON_LO));

    // R6: bank 3 only keeps its low special-register offsets.
    a_r6_shadow_folded: assert property (@(posedge clk) disable iff (!rst_n)
        (phys_addr[8:7] == SHADOW_SRC) |-> (phys_addr[6:0] < SHADOW_LO));

    // R5: the status offset only ever comes out in bank 0.
    a_r5_status_single: assert property (@(posedge clk) disable iff (!rst_n)
        (phys_addr[6:0] == STATUS_OFS) |-> (phys_addr[8:7] == 2'd0));

    // R3: a pointer aimed at an alias read yields read-zero one cycle later.
    a_r3_alias_read: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_rd && ofs_field == 7'd0 && ptr[6:0] == 7'd0) |=> (rd_zero && phys_addr == 9'd0));

    // R8: flags only follow a real access of the previous cycle.
    a_r8_flag_source: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_zero || wr_kill || unimpl) |-> out_valid);

    // R10: an idle cycle leaves no flag behind.
    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc_rd && !acc_wr) |=> (!rd_zero && !wr_kill && !unimpl && !out_valid));
endmodule

// File: tb/bank_addr_gen_test.sv
module bank_addr_gen_test;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       acc_rd, acc_wr, ind_ext;
    logic [6:0] ofs_field;
    logic [1:0] bank_sel;
    logic [7:0] ptr;
    logic       out_valid, rd_zero, wr_kill, unimpl;
    logic [8:0] phys_addr;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    bank_addr_gen uut (
        .clk(clk), .rst_n(rst_n), .acc_rd(acc_rd), .acc_wr(acc_wr),
        .ofs_field(ofs_field), .bank_sel(bank_sel), .ind_ext(ind_ext), .ptr(ptr),
        .out_valid(out_valid), .phys_addr(phys_addr), .rd_zero(rd_zero),
        .wr_kill(wr_kill), .unimpl(unimpl)
    );

    // Expected {valid, rd_zero, wr_kill, unimpl, addr}
    function automatic logic [12:0] model(logic rd, logic wr, logic [1:0] rp,
                                          logic ie, logic [7:0] p, logic [6:0] o);
        logic [8:0] lg, a;
        logic ind, self, un, acc;
        ind  = (o == 7'd0);
        lg   = ind ? {ie, p} : {rp, o};
        self = ind && (lg[6:0] == 7'd0);
        if (self)                                   a = 9'd0;
        else if (lg[6:0] == 7'h03)                  a = 9'h003;
        else if (lg[6:0] >= 7'h70)                  a = {2'b00, lg[6:0]};
        else if (lg[8:7] == 2'd3 && lg[6:0] >= 7'h20) a = {2'b01, lg[6:0]};
        else                                        a = lg;
        un  = !self && a[8:7] == 2'd0 && a[6:0] >= 7'h07 && a[6:0] <= 7'h09;
        acc = rd | wr;
        return {acc, rd & (self | un), wr & (self | un), acc & un, a};
    endfunction

    function automatic string tag_of(logic rd, logic wr, logic [1:0] rp,
                                     logic ie, logic [7:0] p, logic [6:0] o);
        logic [8:0] lg;
        lg = (o == 7'd0) ? {ie, p} : {rp, o};
        if (!rd && !wr)                          return "R10";
        if (o == 7'd0 && lg[6:0] == 7'd0)        return "R3";
        if (lg[6:0] == 7'h03)                    return "R5";
        if (lg[6:0] >= 7'h70)                    return "R4";
        if (lg[8:7] == 2'd3 && lg[6:0] >= 7'h20) return "R6";
        if (lg[8:7] == 2'd0 && lg[6:0] >= 7'h07 && lg[6:0] <= 7'h09) return "R7";
        if (o == 7'd0)                           return "R2";
        return "R1";
    endfunction

    task automatic check(string tag, logic [12:0] exp);
        logic [12:0] act;
        act = {out_valid, rd_zero, wr_kill, unimpl, phys_addr};
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s (R8 timing): actual %h expected %h", tag, act, exp);
        end
    endtask

    // Drive at the falling edge, sample 1 ns after the next rising edge.
    task automatic run(logic rd, logic wr, logic [1:0] rp, logic ie,
                       logic [7:0] p, logic [6:0] o);
        @(negedge clk);
        acc_rd = rd; acc_wr = wr; bank_sel = rp; ind_ext = ie; ptr = p; ofs_field = o;
        @(posedge clk);
        #1;
        check(tag_of(rd, wr, rp, ie, p, o), model(rd, wr, rp, ie, p, o));
    endtask

    initial begin
        #2000000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] seed;
        rst_n = 0; acc_rd = 1; acc_wr = 1; bank_sel = 2'd3; ind_ext = 1;
        ptr = 8'h00; ofs_field = 7'h00;
        repeat (3) @(posedge clk);
        #1;
        check("R9", 13'd0);
        @(negedge clk);
        rst_n = 1;

        run(1, 0, 2'd1, 0, 8'h00, 7'h25);   // R1 direct bank 1 -> 0A5
        run(1, 0, 2'd2, 0, 8'h00, 7'h11);   // R1 direct bank 2 SFR
        run(1, 0, 2'd0, 1, 8'h45, 7'h00);   // R2 pointer high half -> 145
        run(1, 0, 2'd0, 0, 8'h00, 7'h00);   // R3 alias read
        run(0, 1, 2'd2, 0, 8'h80, 7'h00);   // R3 alias write via 080
        run(0, 1, 2'd2, 0, 8'h00, 7'h75);   // R4 bank 2 window -> 075
        run(1, 0, 2'd3, 0, 8'h00, 7'h7F);   // R4 bank 3 window -> 07F
        run(1, 0, 2'd3, 0, 8'h00, 7'h03);   // R5 -> 003
        run(0, 1, 2'd3, 0, 8'h00, 7'h40);   // R6 -> 0C0
        run(1, 0, 2'd3, 0, 8'h00, 7'h6F);   // R6 upper edge -> 0EF
        run(1, 0, 2'd3, 0, 8'h00, 7'h1F);   // R1 bank 3 below shadow
        run(1, 0, 2'd0, 0, 8'h00, 7'h08);   // R7 read unimplemented
        run(0, 1, 2'd0, 0, 8'h09, 7'h00);   // R7 write via pointer
        run(1, 0, 2'd2, 0, 8'h00, 7'h07);   // R1 bank 2 offset 07 implemented
        run(0, 0, 2'd0, 0, 8'h00, 7'h08);   // R10 idle on unimplemented
        run(0, 0, 2'd3, 0, 8'h00, 7'h50);   // R10 idle still folds

        seed = 32'd1234;
        void'($urandom(seed));
        for (int i = 0; i < 400; i++) begin
            logic [3:0] kind;
            logic [6:0] o;
            kind = 4'($urandom_range(0, 15));
            o = (kind < 4) ? 7'h00 : 7'($urandom);
            run(kind[0] | (kind == 4'd8), kind[1], 2'($urandom), 1'($urandom),
                (kind == 4'd2) ? {1'($urandom), 7'h00} : 8'($urandom), o);
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule